// File: doc/BRIEF.md
# Multi-Channel Byte-Command I2C Master

This block is one I2C master engine shared by several physical I2C buses. Software runs the bus one byte at a time. It loads the outgoing byte into a transmit register. It then writes a single command word that chooses the channel, optionally asks for a START, selects a write or a read, optionally enables ACK on a read, and optionally asks for a STOP once the byte is done. Only one byte command is in flight at a time. Every channel shares a single level interrupt that signals completion.

The address phase is an ordinary write command with the START flag set. Its byte is the 7-bit target address shifted left by one, with bit 0 set to 1 for a read and 0 for a write. A quarter-period tick, taken from the system clock and a programmable prescaler, paces the bit engine. SCL and SDA are open-drain: an output-enable of 1 pulls the line low and 0 releases it. Register map: 0 config (bit 0 enable, bits [15:8] prescale, reset value 8 with enable clear); 1 command/status; 2 transmit byte; 3 receive byte; 4 interrupt status (bit 0, write 1 to clear).

Top module: `i2c_mux_master`

## Requirements
- R1: Bus activity appears only on the channel named by command bits [9:8]. Every other channel keeps SCL and SDA released.
- R2: A command with bit 0 (START) set first makes SDA fall while SCL is high. It then shifts the transmit byte out MSB first on eight SCL pulses. A write is command bit 1.
- R3: A read (command bit 2) samples eight bits MSB first into the receive register. It pulls SDA low on the ninth clock only when bit 3 (ACK enable) is set, and otherwise leaves SDA released.
- R4: With bit 4 (STOP) set, SDA rises while SCL is high after the ninth clock. Without it, SCL is held low and SDA is released when the command ends.
- R5: irq_o goes high when a command completes and stays high until a write of 1 to bit 0 of register 4.
- R6: Status bit 5 (busy) of register 1 reads 1 from the cycle after a command is accepted until it completes.
- R7: Status bit 6 (error) is set when the ninth bit of a write byte is sampled high (NACK). It is cleared when the next command is accepted, and the interrupt is still raised.
- R8: Writing zero to register 1 releases both lines of every channel on the next cycle, clears busy and raises no interrupt.
- R9: While config bit 0 is clear, commands are ignored: no bus activity, busy stays 0 and no interrupt is raised.
- R10: The SCL period inside a byte is 4*(prescale+1) clock cycles. Apart from START and STOP, SDA changes only while SCL is low.
- R11: A command written while busy is ignored. The running byte finishes unchanged and nothing happens on the other channel.
- R12: After reset, all output enables and irq_o are 0 and the config register reads 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register index |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| irq_o | output | 1 | Shared completion interrupt, level |
| scl_oe_o | output | NCH | Per-channel SCL pull-low enable |
| sda_oe_o | output | NCH | Per-channel SDA pull-low enable |
| sda_i | input | NCH | Per-channel SDA line level |

## Verification
The bench attaches a target model to every channel and decodes START, byte/ACK and STOP events from the wired lines. It compares these events against those the driver predicts, so a design that drove the wrong channel or sent bits LSB first shows a mismatched or unexpected event. The bench targets several failure modes:
- A target NACK on a write must set the error bit. A design that dropped the error bit, or withheld the interrupt, fails here.
- A read followed by a NACK read must drive ACK only when it is enabled. A design that always acknowledged would make the target drive into the STOP.
- A second command issued while busy must be ignored. A design that accepted it would start traffic on the second channel.
- An abort in mid-byte must release the lines at once and raise no interrupt. A design that kept running would produce extra byte events.
- Changing the prescale must change the SCL period. An off-by-one divider fails the bit-to-bit period check.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [2:0] REG_CFG  = 3'd0;
  localparam logic [2:0] REG_CTRL = 3'd1;
  localparam logic [2:0] REG_TXD  = 3'd2;
  localparam logic [2:0] REG_RXD  = 3'd3;
  localparam logic [2:0] REG_IRQ  = 3'd4;

  localparam int CTL_START  = 0;
  localparam int CTL_WR     = 1;
  localparam int CTL_RD     = 2;
  localparam int CTL_ACK    = 3;
  localparam int CTL_STOP   = 4;
  localparam int CTL_BUSY   = 5;
  localparam int CTL_ERR    = 6;
  localparam int CTL_CH_LSB = 8;
  localparam int CFG_PRE_LSB = 8;

  typedef struct packed {
    logic       start;
    logic       rd;
    logic       ack_en;
    logic       stop;
    logic [7:0] txd;
  } cmd_t;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BIT, PH_STOP} phase_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] pre_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_i,
  input  logic       launch_i,
  input  cmd_t       cmd_i,
  input  logic       tick_i,
  input  logic       sda_in_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_o,
  output logic [7:0] rx_o,
  output logic       scl_lo_o,
  output logic       sda_lo_o
);
  phase_e     phase_q;
  logic [1:0] q_q;
  logic [3:0] bidx_q;
  logic [7:0] sh_q;
  logic       samp_q, held_q, nack_q;
  cmd_t       cmd_q;

  logic last_q, byte_end;
  assign last_q   = tick_i && (q_q == 2'd3);
  assign byte_end = last_q && (phase_q == PH_BIT) && (bidx_q == 4'd8);

  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = (byte_end && !cmd_q.stop) || (last_q && phase_q == PH_STOP);
  assign nack_o = nack_q;
  assign rx_o   = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      q_q     <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      samp_q  <= 1'b1;
      held_q  <= 1'b0;
      nack_q  <= 1'b0;
      cmd_q   <= '0;
    end else if (abort_i) begin
      phase_q <= PH_IDLE;
      held_q  <= 1'b0;
      q_q     <= '0;
    end else if (launch_i) begin
      cmd_q   <= cmd_i;
      sh_q    <= cmd_i.txd;
      q_q     <= '0;
      bidx_q  <= '0;
      nack_q  <= 1'b0;
      phase_q <= cmd_i.start ? PH_START : PH_BIT;
    end else if (tick_i) begin
      q_q <= q_q + 1'b1;
      unique case (phase_q)
        PH_START: if (q_q == 2'd3) phase_q <= PH_BIT;
        PH_BIT: begin
          if (q_q == 2'd2) samp_q <= sda_in_i;
          if (q_q == 2'd3) begin
            if (bidx_q == 4'd8) begin
              nack_q <= samp_q & ~cmd_q.rd;
              bidx_q <= '0;
              if (cmd_q.stop) phase_q <= PH_STOP;
              else begin
                phase_q <= PH_IDLE;
                held_q  <= 1'b1;
              end
            end else begin
              sh_q   <= {sh_q[6:0], samp_q};
              bidx_q <= bidx_q + 1'b1;
            end
          end
        end
        PH_STOP: if (q_q == 2'd3) begin
          phase_q <= PH_IDLE;
          held_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // quarter 0 and 3 keep SCL low so SDA only moves with the clock low
  always_comb begin
    scl_lo_o = 1'b0;
    sda_lo_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: scl_lo_o = held_q;
      PH_START: begin
        scl_lo_o = (q_q == 2'd0) || (q_q == 2'd3);
        sda_lo_o = q_q[1];
      end
      PH_BIT: begin
        scl_lo_o = (q_q == 2'd0) || (q_q == 2'd3);
        if (bidx_q == 4'd8) sda_lo_o = cmd_q.rd & cmd_q.ack_en;
        else                sda_lo_o = ~cmd_q.rd & ~sh_q[7];
      end
      PH_STOP: begin
        scl_lo_o = (q_q == 2'd0);
        sda_lo_o = ~q_q[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2cm_chan_mux.sv
module i2cm_chan_mux #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CW-1:0]  sel_i,
  input  logic           scl_lo_i,
  input  logic           sda_lo_i,
  input  logic [NCH-1:0] sda_i,
  output logic [NCH-1:0] scl_oe_o,
  output logic [NCH-1:0] sda_oe_o,
  output logic           sda_sel_o
);
  logic [NCH-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= sda_i;
      sync2_q <= sync1_q;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit         = (sel_i == CW'(i));
    assign scl_oe_o[i] = hit & scl_lo_i;
    assign sda_oe_o[i] = hit & sda_lo_i;
  end

  always_comb begin
    sda_sel_o = 1'b1;
    for (int i = 0; i < NCH; i++)
      if (sel_i == CW'(i)) sda_sel_o = sync2_q[i];
  end
endmodule

// File: rtl/i2c_mux_master.sv
module i2c_mux_master
  import i2cm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 8,
  parameter int DW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [2:0]     addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           irq_o,
  output logic [NCH-1:0] scl_oe_o,
  output logic [NCH-1:0] sda_oe_o,
  input  logic [NCH-1:0] sda_i
);
  logic          en_q, irq_q, rd_q;
  logic [PW-1:0] pre_q;
  logic [7:0]    txd_q, rxd_q;
  logic [CW-1:0] ch_q;

  logic wr_ctrl, abort, launch, tick;
  logic eng_busy, eng_done, eng_nack, scl_lo, sda_lo, sda_sel;
  logic [7:0] eng_rx;
  cmd_t cmd;

  assign wr_ctrl = we_i && (addr_i == REG_CTRL);
  assign abort   = (wr_ctrl && (wdata_i == '0)) ||
                   (we_i && addr_i == REG_CFG && !wdata_i[0]);
  assign launch  = wr_ctrl && (wdata_i[CTL_WR] || wdata_i[CTL_RD]) && en_q && !eng_busy;

  assign cmd.start  = wdata_i[CTL_START];
  assign cmd.rd     = wdata_i[CTL_RD];
  assign cmd.ack_en = wdata_i[CTL_ACK];
  assign cmd.stop   = wdata_i[CTL_STOP];
  assign cmd.txd    = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      pre_q <= PW'(8);
      txd_q <= '0;
      rxd_q <= '0;
      ch_q  <= '0;
      rd_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (we_i && addr_i == REG_CFG) begin
        en_q  <= wdata_i[0];
        pre_q <= wdata_i[CFG_PRE_LSB +: PW];
      end
      if (we_i && addr_i == REG_TXD) txd_q <= wdata_i[7:0];
      if (launch) begin
        ch_q <= wdata_i[CTL_CH_LSB +: CW];
        rd_q <= wdata_i[CTL_RD];
      end
      if (eng_done && !abort) begin
        irq_q <= 1'b1;
        if (rd_q) rxd_q <= eng_rx;
      end else if (we_i && addr_i == REG_IRQ && wdata_i[0]) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CFG: begin
        rdata_o[0] = en_q;
        rdata_o[CFG_PRE_LSB +: PW] = pre_q;
      end
      REG_CTRL: begin
        rdata_o[CTL_BUSY] = eng_busy;
        rdata_o[CTL_ERR]  = eng_nack;
        rdata_o[CTL_CH_LSB +: CW] = ch_q;
      end
      REG_TXD: rdata_o[7:0] = txd_q;
      REG_RXD: rdata_o[7:0] = rxd_q;
      REG_IRQ: rdata_o[0]   = irq_q;
      default: ;
    endcase
  end

  i2cm_tick #(.PW(PW)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (eng_busy),
    .pre_i (pre_q),
    .tick_o(tick)
  );

  i2cm_engine u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (abort),
    .launch_i(launch),
    .cmd_i   (cmd),
    .tick_i  (tick),
    .sda_in_i(sda_sel),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .nack_o  (eng_nack),
    .rx_o    (eng_rx),
    .scl_lo_o(scl_lo),
    .sda_lo_o(sda_lo)
  );

  i2cm_chan_mux #(.NCH(NCH)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (ch_q),
    .scl_lo_i (scl_lo),
    .sda_lo_i (sda_lo),
    .sda_i    (sda_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .sda_sel_o(sda_sel)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           we_i,
  input logic [2:0]     addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic           irq_i,
  input logic [NCH-1:0] scl_oe_i,
  input logic [NCH-1:0] sda_oe_i,
  input logic           busy_i,
  input logic           en_i
);
  AST_ONE_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(scl_oe_i | sda_oe_i)); // R1

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !(we_i && addr_i == 3'd4 && wdata_i[0])) |=> irq_i); // R5

  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> !busy_i); // R6

  AST_ABORT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd1 && wdata_i == '0) |=> (scl_oe_i == '0 && sda_oe_i == '0 && !busy_i)); // R8

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !busy_i) |=> !busy_i); // R9
endmodule

bind i2c_mux_master i2cm_checker #(.NCH(NCH), .DW(DW)) u_i2cm_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_i   (irq_o),
  .scl_oe_i(scl_oe_o),
  .sda_oe_i(sda_oe_o),
  .busy_i  (eng_busy),
  .en_i    (en_q)
);

// File: tb/test_i2c_mux_master.sv
module test_i2c_mux_master;
  localparam int NCH = 4;
  localparam logic [2:0] A_CFG = 3'd0, A_CTRL = 3'd1, A_TXD = 3'd2, A_RXD = 3'd3, A_IRQ = 3'd4;
  localparam logic [1:0] EV_START = 2'd1, EV_STOP = 2'd2, EV_BYTE = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  logic [NCH-1:0] scl_oe, sda_oe, sda_line, scl_line, pull;

  int checks = 0, fails = 0;
  int cur_pre = 8;
  bit slv_tx_mode = 1'b0, slv_ack = 1'b1;
  logic [7:0] slv_tx = 8'h00;
  logic [12:0] exp_q[$];

  logic [3:0] sidx[NCH];
  int rises[NCH];
  longint last_rise[NCH];
  logic [7:0] shreg[NCH];
  bit mnack[NCH];
  logic [NCH-1:0] p_scl, p_sda;
  longint cyc = 0;

  always #5 clk = ~clk;

  i2c_mux_master #(.NCH(NCH)) i_i2c_mux_master (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (slv_tx_mode) pull[i] = (sidx[i] < 4'd8) && !slv_tx[3'd7 - sidx[i][2:0]];
      else             pull[i] = (sidx[i] == 4'd8) && slv_ack;
      scl_line[i] = ~scl_oe[i];
      sda_line[i] = ~(sda_oe[i] | pull[i]);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: observed bus events are matched against the driver's queue
  task automatic observe(input logic [12:0] ev);
    logic [12:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R1 unexpected bus event", ev, 0);
    end else begin
      e = exp_q.pop_front();
      chk(ev == e, "R1/R2/R3/R4 bus event", ev, e);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        sidx[i] <= 4'd9; rises[i] = 0; shreg[i] = '0; mnack[i] = 1'b0; last_rise[i] = 0;
      end
      p_scl = '1; p_sda = '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (p_scl[i] && scl_line[i] && p_sda[i] && !sda_line[i]) begin
          observe({EV_START, 2'(i), 1'b0, 8'h00});
          rises[i] = 0; sidx[i] <= 4'd0; mnack[i] = 1'b0;
        end else if (p_scl[i] && scl_line[i] && !p_sda[i] && sda_line[i]) begin
          observe({EV_STOP, 2'(i), 1'b0, 8'h00});
          rises[i] = 0; sidx[i] <= 4'd9;
        end
        if (!p_scl[i] && scl_line[i]) begin
          if (rises[i] >= 1 && rises[i] <= 8)
            chk(cyc - last_rise[i] == 4 * (cur_pre + 1), "R10 SCL period",
                cyc - last_rise[i], 4 * (cur_pre + 1));
          last_rise[i] = cyc;
          if (rises[i] < 8) shreg[i] = {shreg[i][6:0], sda_line[i]};
          else if (rises[i] == 8) begin
            observe({EV_BYTE, 2'(i), sda_line[i], shreg[i]});
            mnack[i] = slv_tx_mode && sda_line[i];
          end
          if (rises[i] < 9) rises[i]++;
        end
        if (p_scl[i] && !scl_line[i]) begin
          if (rises[i] == 9) begin
            rises[i] = 0;
            sidx[i] <= mnack[i] ? 4'd9 : 4'd0;
          end else sidx[i] <= 4'(rises[i]);
        end
      end
      p_scl = scl_line; p_sda = sda_line;
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_irq(output bit got);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    got = irq;
  endtask

  task automatic clear_irq();
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R5 irq held until cleared", irq, 1);
    reg_wr(A_IRQ, 32'h1);
    #1 chk(irq == 1'b0, "R5 irq cleared by write 1", irq, 0);
  endtask

  // driver: predicts bus events, issues one byte command, waits for completion
  task automatic do_cmd(input int ch, input bit st, input bit rd, input bit ack, input bit sp,
                        input logic [7:0] tx);
    logic [31:0] d;
    bit got;
    if (st) exp_q.push_back({EV_START, 2'(ch), 1'b0, 8'h00});
    exp_q.push_back({EV_BYTE, 2'(ch), rd ? !ack : !slv_ack, rd ? slv_tx : tx});
    if (sp) exp_q.push_back({EV_STOP, 2'(ch), 1'b0, 8'h00});
    reg_wr(A_TXD, {24'h0, tx});
    reg_wr(A_CTRL, (ch << 8) | (sp << 4) | (ack << 3) | (rd << 2) | ((!rd) << 1) | st);
    reg_rd(A_CTRL, d);
    chk(d[5] == 1'b1, "R6 busy after launch", d[5], 1);
    wait_irq(got);
    chk(got, "R5 completion irq", got, 1);
    reg_rd(A_CTRL, d);
    chk(d[5] == 1'b0, "R6 busy clear at completion", d[5], 0);
    chk(exp_q.size() == 0, "R2 all predicted events seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit got;
    repeat (3) @(negedge clk);
    chk(scl_oe == '0 && sda_oe == '0, "R12 lines released in reset", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    reg_rd(A_CFG, d);
    chk(d == 32'h800, "R12 config reset value", d, 32'h800);
    chk(irq == 1'b0, "R12 irq low after reset", irq, 0);

    // R9: disabled, command ignored
    reg_wr(A_TXD, 32'h55);
    reg_wr(A_CTRL, 32'h0000_0113);
    reg_rd(A_CTRL, d);
    chk(d[5] == 1'b0, "R9 no busy when disabled", d[5], 0);
    repeat (300) @(negedge clk);
    chk(irq == 1'b0 && scl_oe == '0, "R9 no irq or bus when disabled", {irq, scl_oe}, 0);

    cur_pre = 1;
    reg_wr(A_CFG, 32'h0000_0101);

    // write transaction on channel 1
    slv_ack = 1'b1; slv_tx_mode = 1'b0;
    do_cmd(1, 1, 0, 0, 0, 8'hA0);
    chk(scl_oe == 4'b0010 && sda_oe == '0, "R4 SCL held low without STOP", {scl_oe, sda_oe}, 8'h20);
    clear_irq();
    do_cmd(1, 0, 0, 0, 0, 8'hA5);
    clear_irq();
    do_cmd(1, 0, 0, 0, 1, 8'h3C);
    chk(scl_oe == '0 && sda_oe == '0, "R4 lines released after STOP", {scl_oe, sda_oe}, 0);
    reg_rd(A_CTRL, d);
    chk(d[6] == 1'b0, "R7 no error on acked write", d[6], 0);
    clear_irq();

    // R7: NACK on channel 2
    slv_ack = 1'b0;
    do_cmd(2, 1, 0, 0, 1, 8'hB4);
    reg_rd(A_CTRL, d);
    chk(d[6] == 1'b1, "R7 error on NACK", d[6], 1);
    clear_irq();
    slv_ack = 1'b1;

    // R3: read on channel 3
    do_cmd(3, 1, 0, 0, 0, 8'hA1);
    reg_rd(A_CTRL, d);
    chk(d[6] == 1'b0, "R7 error cleared by next command", d[6], 0);
    clear_irq();
    slv_tx = 8'h96; slv_tx_mode = 1'b1;
    do_cmd(3, 0, 1, 1, 0, 8'h00);
    reg_rd(A_RXD, d);
    chk(d[7:0] == 8'h96, "R3 received byte with ACK", d[7:0], 8'h96);
    clear_irq();
    slv_tx = 8'h5B;
    do_cmd(3, 0, 1, 0, 1, 8'h00);
    reg_rd(A_RXD, d);
    chk(d[7:0] == 8'h5B, "R3 received byte with NACK", d[7:0], 8'h5B);
    clear_irq();
    slv_tx_mode = 1'b0;

    // repeated START on channel 0
    do_cmd(0, 1, 0, 0, 0, 8'h40);
    clear_irq();
    do_cmd(0, 1, 0, 0, 1, 8'h41);
    clear_irq();

    // R11: command while busy ignored
    exp_q.push_back({EV_START, 2'd0, 1'b0, 8'h00});
    exp_q.push_back({EV_BYTE, 2'd0, 1'b0, 8'hC6});
    exp_q.push_back({EV_STOP, 2'd0, 1'b0, 8'h00});
    reg_wr(A_TXD, 32'hC6);
    reg_wr(A_CTRL, 32'h0000_0013);
    reg_wr(A_CTRL, 32'h0000_0213);
    wait_irq(got);
    chk(got && exp_q.size() == 0, "R11 busy command ignored", exp_q.size(), 0);
    clear_irq();
    repeat (200) @(negedge clk);
    chk(scl_oe == '0, "R11 no later traffic", scl_oe, 0);

    // R8: abort in mid-byte
    exp_q.push_back({EV_START, 2'd2, 1'b0, 8'h00});
    reg_wr(A_TXD, 32'hFF);
    reg_wr(A_CTRL, 32'h0000_0213);
    repeat (20) @(negedge clk);
    reg_wr(A_CTRL, 32'h0);
    chk(scl_oe == '0 && sda_oe == '0, "R8 abort releases lines", {scl_oe, sda_oe}, 0);
    reg_rd(A_CTRL, d);
    chk(d[5] == 1'b0, "R8 abort clears busy", d[5], 0);
    repeat (300) @(negedge clk);
    chk(irq == 1'b0 && exp_q.size() == 0, "R8 no irq after abort", {irq, exp_q.size()}, 0);

    // R10: slower prescale
    cur_pre = 3;
    reg_wr(A_CFG, 32'h0000_0301);
    do_cmd(1, 1, 0, 0, 1, 8'h6E);
    clear_irq();

    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule